// File: doc/BRIEF.md
# MDIO Management Master

This block is the station-side master of a two-wire management bus. It derives the management clock (MDC) from the system clock and runs complete clause-22 read and write transactions. To start one, the host places an operation, a 5-bit PHY address, a 5-bit register address and 16 bits of write data on its inputs and pulses `start` for one system clock. The block raises `busy` and sends 32 preamble ones, the start pattern, the opcode and both addresses. It then either drives the write turnaround and data, or releases the line and shifts in 16 bits that the PHY returns.

The divider's half-period is computed from the system clock frequency. Each MDC level therefore lasts at least 160 ns, and each full MDC period lasts at least 400 ns. Outside a transaction MDC stays low and the data line is released. When the last MDC period ends, `done` pulses for one system clock and `busy` falls. After a read, `rd_data` holds the captured word from that point until another read completes.

Top module: `mdio_master`

## Requirements
- R1: Any two consecutive MDC edges are separated by at least ceil(160 ns x f_sys) system clocks. The half-period used is max(ceil(160 ns x f_sys), ceil(200 ns x f_sys)), which is 20 clocks at 100 MHz.
- R2: Two consecutive rising MDC edges, or two consecutive falling ones, are at least 400 ns apart.
- R3: Every frame begins with 32 bits of 1 on the data line, followed by a 0 and then a 1.
- R4: After the start bits the master sends the opcode (1,0 for a read, 0,1 for a write), then the 5-bit PHY address, then the 5-bit register address, each field MSB first.
- R5: In a write, the master drives a 1 and then a 0 in the two turnaround slots (frame slots 46 and 47), then the 16 data bits bit 15 first. The output enable stays high for all 64 slots.
- R6: In a read, the output enable is low for slots 46 to 63. The 16 bits sampled on the rising MDC edges of slots 48 to 63 form `rd_data`, with the first sampled bit as bit 15.
- R7: While a frame is running, the driven data bit and the output enable change only in the same system clock in which MDC falls. The PHY samples at rising MDC edges.
- R8: When no transaction is in progress, MDC is low and the output enable is low.
- R9: A `start` pulse seen while `busy` is high is ignored. The running frame continues unchanged and no further frame follows it.
- R10: `done` is high for exactly one system clock, in the clock in which `busy` falls. `rd_data` changes only at the end of a read and is unaffected by writes.
- R11: A transaction consists of exactly 64 MDC periods and lasts 128 half-periods, measured from the clock edge that accepts `start` to the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-clock request to begin a transaction |
| op_read | input | 1 | 1 selects a read, 0 selects a write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for a write |
| busy | output | 1 | High while a frame is in progress |
| done | output | 1 | One-clock pulse at the end of a frame |
| rd_data | output | 16 | Word captured by the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value toward the pad |
| mdio_oe | output | 1 | Output enable toward the pad |
| mdio_i | input | 1 | Data value from the pad |

## Verification
The hardest case to reach from the ports is a start request that arrives in the middle of a running frame with different operation and address values. The bench raises `start` about 700 clocks into a write, with read settings on the inputs. It then checks that the frame the PHY model receives is still the original write, that it contains exactly 64 MDC periods, and that no second frame starts afterwards. A bench-side PHY model drives the line only after the falling edges of the read data slots. As a result, a wrong release window or a wrong sampling edge shows up as corrupted read data.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_SLOT    = 46;
  localparam int DATA_SLOT  = 48;
  localparam int DATA_BITS  = 16;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // half-period in system clocks: must satisfy the edge gap and half of the full cycle
  function automatic int mdc_half_cycles(input int sys_mhz);
    int gap_min;
    int cyc_min;
    gap_min = ceil_div(160 * sys_mhz, 1000);
    cyc_min = ceil_div(400 * sys_mhz, 2000);
    return (gap_min > cyc_min) ? gap_min : cyc_min;
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(input logic rd,
                                                        input logic [4:0] phy,
                                                        input logic [4:0] regad,
                                                        input logic [15:0] wd);
    logic [1:0]  opc;
    logic [1:0]  ta;
    logic [15:0] dat;
    opc = rd ? 2'b10 : 2'b01;
    ta  = rd ? 2'b11 : 2'b10;
    dat = rd ? 16'hFFFF : wd;
    return {{PRE_BITS{1'b1}}, 2'b01, opc, phy, regad, ta, dat};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] TERM = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick     = run && (cnt == TERM);
  assign rise_evt = tick && !mdc;
  assign fall_evt = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R8
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        op_read,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  input  logic        rise_evt,
  input  logic        fall_evt,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        last_fall
);
  localparam int SW = $clog2(FRAME_BITS);
  localparam logic [SW-1:0] LAST_SLOT = SW'(FRAME_BITS - 1);
  localparam logic [SW-1:0] TA_FIRST  = SW'(TA_SLOT);
  localparam logic [SW-1:0] DAT_FIRST = SW'(DATA_SLOT);

  logic [FRAME_BITS-1:0] shreg;
  logic [SW-1:0]         slot;
  logic                  is_rd;
  logic [DATA_BITS-1:0]  cap;
  logic                  accept;
  logic                  released;
  logic                  capture;

  assign accept    = start && !busy;
  assign last_fall = busy && fall_evt && (slot == LAST_SLOT);
  assign released  = is_rd && (slot >= TA_FIRST);
  assign capture   = busy && rise_evt && is_rd && (slot >= DAT_FIRST);

  assign mdio_o  = busy ? shreg[FRAME_BITS-1] : 1'b1;
  assign mdio_oe = busy && !released;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      slot    <= '0;
      shreg   <= '1;
      is_rd   <= 1'b0;
      cap     <= '0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        slot  <= '0;
        is_rd <= op_read;
        shreg <= build_frame(op_read, phy_addr, reg_addr, wr_data);
      end else if (busy) begin
        if (capture) cap <= {cap[DATA_BITS-2:0], mdio_i};
        if (fall_evt) begin
          if (slot == LAST_SLOT) begin
            busy <= 1'b0;
            done <= 1'b1;
            if (is_rd) rd_data <= cap;
          end else begin
            slot  <= slot + 1'b1;
            shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
          end
        end
      end
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last_fall |=> busy);
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int SYS_CLK_MHZ = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        op_read,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int HALF = mdio_pkg::mdc_half_cycles(SYS_CLK_MHZ);
  localparam int GW   = $clog2(HALF + 2);

  logic rise_evt;
  logic fall_evt;
  logic last_fall;

  mdio_mdc_gen #(.HALF(HALF)) u_mdc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_read   (op_read),
    .phy_addr  (phy_addr),
    .reg_addr  (reg_addr),
    .wr_data   (wr_data),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .mdio_i    (mdio_i),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .last_fall (last_fall)
  );

  // edge spacing observer for the timing assertions
  logic          mdc_prev;
  logic [GW-1:0] gap;
  logic [GW-1:0] prev_gap;
  logic          mdc_moved;

  assign mdc_moved = (mdc != mdc_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_prev <= 1'b0;
      gap      <= GW'(HALF);
      prev_gap <= GW'(HALF);
    end else begin
      mdc_prev <= mdc;
      if (mdc_moved) begin
        prev_gap <= gap;
        gap      <= GW'(1);
      end else if (gap < GW'(HALF)) begin
        gap <= gap + 1'b1;
      end
    end
  end

  // R1
  initial divider_cfg_chk: assert (HALF * 1000 >= 160 * SYS_CLK_MHZ && 2 * HALF * 1000 >= 400 * SYS_CLK_MHZ);

  // R1
  edge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdc_moved |-> gap >= GW'(HALF));
  // R2
  full_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdc_moved |-> ({1'b0, gap} + {1'b0, prev_gap}) >= (GW+1)'(2 * HALF));
  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$fell(busy) |-> !mdc && !mdio_oe);
  // R7
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && (mdio_o != $past(mdio_o)) |-> $fell(mdc));
  // R6
  release_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $fell(mdio_oe) |-> $fell(mdc));
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int CLK_NS   = 10;
  localparam int MHZ      = 100;
  localparam int HALF_EXP = 20;   // 200 ns at 10 ns per clock
  localparam int NVEC     = 7;

  // {read, phy, reg, data}: data is write data or the PHY's reply
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b0, 5'h01, 5'h00, 16'hA5C3},
    {1'b1, 5'h1F, 5'h1F, 16'h8001},
    {1'b0, 5'h10, 5'h0A, 16'h0000},
    {1'b1, 5'h00, 5'h01, 16'hFFFF},
    {1'b0, 5'h1F, 5'h15, 16'hFFFF},
    {1'b1, 5'h0B, 5'h12, 16'h0000},
    {1'b1, 5'h05, 5'h03, 16'h7E5A}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_read = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy, done, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  mdio_master #(.SYS_CLK_MHZ(MHZ)) u_mdio_master (
    .clk(clk), .rst_n(rst_n), .start(start), .op_read(op_read),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_NS/2) clk = ~clk;

  // PHY model
  logic [63:0] seen_bits = '0;
  logic [63:0] seen_oe = '0;
  logic [15:0] phy_data = '0;
  int rises = 0;
  int falls = 0;

  always @(posedge mdc) begin
    seen_bits = {seen_bits[62:0], mdio_o};
    seen_oe   = {seen_oe[62:0], mdio_oe};
    rises++;
  end

  always @(negedge mdc) begin
    falls++;
    mdio_i = (falls >= 48 && falls <= 63) ? phy_data[63 - falls] : 1'b1;
  end

  // edge timing monitor, in system clocks
  int gap = 1000;
  int last_gap = 1000;
  int gap_bad = 0;
  int per_bad = 0;
  logic last_mdc = 1'b0;

  always @(negedge clk) begin
    if (mdc !== last_mdc) begin
      if (gap < HALF_EXP) gap_bad++;
      if (gap + last_gap < 2 * HALF_EXP) per_bad++;
      last_gap = gap;
      gap = 1;
    end else if (gap < 1000) begin
      gap++;
    end
    last_mdc = mdc;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    logic [63:0] f;
    f[63:32] = 32'hFFFF_FFFF;
    f[31:30] = 2'b01;
    f[29:28] = rd ? 2'b10 : 2'b01;
    f[27:23] = p;
    f[22:18] = r;
    f[17:16] = 2'b10;
    f[15:0]  = d;
    return f;
  endfunction

  task automatic run_txn(input logic rd, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] d, input bit inject);
    logic [63:0] ef;
    logic [63:0] eoe;
    logic [15:0] rd_before;
    int cyc;
    rd_before = rd_data;
    phy_data = d;
    rises = 0;
    falls = 0;
    @(negedge clk);
    op_read = rd; phy_addr = p; reg_addr = r; wr_data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R11 busy after start", {63'b0, busy}, 64'd1);
    cyc = 0;
    while (done !== 1'b1 && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (inject && cyc == 700) begin
        op_read = ~rd; phy_addr = ~p; reg_addr = ~r; wr_data = ~d; start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    check(cyc == 128 * HALF_EXP, "R11 frame duration", 64'(cyc), 64'(128 * HALF_EXP));
    check(rises == 64 && falls == 64, "R11 mdc period count", 64'(rises), 64'd64);
    check(busy === 1'b0, "R10 busy low with done", {63'b0, busy}, 64'd0);
    ef = exp_frame(rd, p, r, d);
    check(seen_bits[63:30] === ef[63:30], "R3 preamble and start", seen_bits, ef);
    check(seen_bits[29:18] === ef[29:18], "R4 opcode and addresses", seen_bits, ef);
    eoe = rd ? {{46{1'b1}}, 18'b0} : '1;
    check(seen_oe === eoe, rd ? "R6 release window" : "R5 drive window", seen_oe, eoe);
    if (rd) begin
      check(rd_data === d, "R6 read data", 64'(rd_data), 64'(d));
    end else begin
      check(seen_bits[17:0] === ef[17:0], "R5 turnaround and data", seen_bits, ef);
      check(rd_data === rd_before, "R10 rd_data kept over write", 64'(rd_data), 64'(rd_before));
    end
    @(negedge clk);
    check(done === 1'b0, "R10 done single cycle", {63'b0, done}, 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && mdc === 1'b0 && mdio_oe === 1'b0,
          "R8 reset state", {60'b0, busy, done, mdc, mdio_oe}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      run_txn(VEC[i][26], VEC[i][25:21], VEC[i][20:16], VEC[i][15:0], 1'b0);
      repeat (5) @(negedge clk);
    end

    // R9: start during a running write is ignored
    run_txn(1'b0, 5'h0C, 5'h07, 16'h3C96, 1'b1);
    repeat (3 * HALF_EXP) @(negedge clk);
    check(busy === 1'b0 && mdc === 1'b0, "R9 no frame after ignored start",
          {62'b0, busy, mdc}, 64'd0);

    // R8: idle line stays quiet
    repeat (100) @(negedge clk);
    check(mdc === 1'b0 && mdio_oe === 1'b0, "R8 idle mdc low and released",
          {62'b0, mdc, mdio_oe}, 64'd0);

    // R10: back-to-back start right after done
    run_txn(1'b1, 5'h02, 5'h1E, 16'h1234, 1'b0);
    run_txn(1'b0, 5'h02, 5'h1E, 16'hBEEF, 1'b0);

    check(gap_bad == 0, "R1 edge spacing", 64'(gap_bad), 64'd0);
    check(per_bad == 0, "R2 full period", 64'(per_bad), 64'd0);
    summary();
  end
endmodule